// File: doc/BRIEF.md
# Three-Channel Fast PWM Generator

This block produces three pulse-width-modulated outputs that share one free-running up-counter. The counter runs from zero to its all-ones TOP value and wraps back to zero, so one PWM period is 2^CNT_W counter steps (256 steps at the default 8-bit width). Each channel compares the counter with its own compare value. The output goes high when the counter wraps and drops after the count passes the compare value. A larger compare value therefore gives a longer high time. Even a compare value of zero leaves a one-step pulse at the start of every period, so the output is never constantly low.

Compare values are loaded through a small write port: a write strobe, a channel select and a data word. A write lands in a per-channel holding register. The value that drives the comparison is refreshed from that register only when the counter wraps, so a period already in progress is never cut short or stretched. A clock-enable input paces the counter as a prescaler hook; tie it high to count every clock. A per-channel enable forces that channel's output low. Outputs are always driven to a firm 0 or 1.

Top module: `pwm3_fast`

## Requirements
- R1: The counter starts at 0 after reset, advances by one on each clock where `tick_en` is high, and wraps from all-ones (TOP) to 0, giving a period of 2^CNT_W ticks.
- R2: While enabled, a channel's output is high exactly in the ticks where counter <= active compare value, which is N+1 ticks per period for compare value N.
- R3: A compare value of 0 gives one high tick (counter 0) per period, never a constant low.
- R4: A compare value equal to TOP (0xFF at default width) keeps the output high for the whole period.
- R5: A write goes to the holding register of the channel selected by `wr_sel` (0, 1 or 2). The active compare value takes the held value only on the tick where the counter steps from TOP to 0, so a write in mid-period has no effect until then.
- R6: When `ch_enable[i]` is low at a clock edge, `pwm_out[i]` is low after that edge.
- R7: After reset, all compare values are 0 and all outputs are low.
- R8: A write issued in the same cycle as the TOP-to-0 step takes effect in the period that begins at that step.
- R9: A write with `wr_sel` of NUM_CH or more changes no channel.
- R10: While `tick_en` is low and the channel enables are steady, the counter and all outputs hold their values.
- R11: Every output is always driven to a known 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| tick_en | input | 1 | Counter clock enable (prescaler hook); high counts every clock |
| wr_en | input | 1 | Compare write strobe |
| wr_sel | input | SEL_W (2) | Channel number for the write |
| wr_data | input | CNT_W (8) | Compare value to write |
| ch_enable | input | NUM_CH (3) | Per-channel output enable |
| pwm_out | output | NUM_CH (3) | PWM outputs |

## Verification
A compare write and the TOP-to-0 reload of the active compare value can fall in the same cycle. There the written value must bypass the holding register and govern the new period at once. The bench tracks a model counter, waits for the cycle in which the next edge wraps, and issues the write in that cycle. It then counts the high ticks of the following period and checks that they equal the new value plus one. The random phase also produces such collisions, and every cycle's outputs are compared with the model.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
   // width of a select field able to address n channels
   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] cnt_d,
   output logic         wrap
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   assign wrap  = tick && (cnt_q == TOP);
   assign cnt_d = tick ? cnt_q + 1'b1 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
   parameter int W      = 8,
   parameter bit SHADOW = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wr_data,
   input  logic         load,
   input  logic         ch_en,
   input  logic [W-1:0] cnt_d,
   output logic [W-1:0] act_q,
   output logic         out_q
);
   logic [W-1:0] act_d;

   if (SHADOW) begin : g_buffered
      logic [W-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  hold_q <= '0;
         else if (wr) hold_q <= wr_data;
      end
      // a write in the reload cycle bypasses the holding register
      always_comb begin
         act_d = act_q;
         if (load) act_d = wr ? wr_data : hold_q;
      end
   end else begin : g_direct
      always_comb act_d = wr ? wr_data : act_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         out_q <= 1'b0;
      end else begin
         act_q <= act_d;
         out_q <= ch_en && (cnt_d <= act_d);
      end
   end
endmodule

// File: rtl/pwm3_fast.sv
module pwm3_fast #(
   parameter int CNT_W  = 8,
   parameter int NUM_CH = 3,
   parameter bit SHADOW = 1'b1,
   localparam int SEL_W = pwm3_pkg::sel_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [NUM_CH-1:0] ch_enable,
   output logic [NUM_CH-1:0] pwm_out
);
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
      $error("pwm3_fast: CNT_W must lie in 2..16");
   end
   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_count
      $error("pwm3_fast: NUM_CH must lie in 1..16");
   end

   logic [CNT_W-1:0]        cnt_q;
   logic [CNT_W-1:0]        cnt_d;
   logic                    wrap;
   logic [NUM_CH*CNT_W-1:0] act_flat;

   pwm_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_en),
      .cnt_q (cnt_q),
      .cnt_d (cnt_d),
      .wrap  (wrap)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit = wr_en && (int'(wr_sel) == i);
      pwm_channel #(.W(CNT_W), .SHADOW(SHADOW)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (hit),
         .wr_data (wr_data),
         .load    (wrap),
         .ch_en   (ch_enable[i]),
         .cnt_d   (cnt_d),
         .act_q   (act_flat[i*CNT_W +: CNT_W]),
         .out_q   (pwm_out[i])
      );
   end
endmodule

// File: rtl/pwm3_fast_chk.sv
module pwm3_fast_chk #(
   parameter int CNT_W  = 8,
   parameter int NUM_CH = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    tick_en,
   input logic [NUM_CH-1:0]       ch_enable,
   input logic [NUM_CH-1:0]       pwm_out,
   input logic [CNT_W-1:0]        cnt,
   input logic [NUM_CH*CNT_W-1:0] act
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && cnt == TOP) |=> (cnt == '0));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && $stable(ch_enable)) |=> ($stable(cnt) && $stable(pwm_out)));

   p_reload_only_at_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick_en && cnt == TOP) |=> $stable(act));

   p_known_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(pwm_out));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_p
      p_off_when_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_enable[i] |=> !pwm_out[i]);

      p_zero_one_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (act[i*CNT_W +: CNT_W] == '0 && cnt != '0) |-> !pwm_out[i]);

      p_full_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_enable[i] && tick_en) |=> ((act[i*CNT_W +: CNT_W] == TOP) -> pwm_out[i]));
   end
endmodule

bind pwm3_fast pwm3_fast_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .ch_enable (ch_enable),
   .pwm_out   (pwm_out),
   .cnt       (cnt_q),
   .act       (act_flat)
);

// File: tb/tb_pwm3_fast.sv
`timescale 1ns/1ps
module tb_pwm3_fast;
   localparam int NCH = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] ch_enable = '0;
   logic [2:0] pwm_out;

   int n_cmp = 0;
   int n_bad = 0;
   string cur_req = "R7";

   // reference state
   logic [7:0] m_cnt;
   logic [7:0] m_hold [NCH];
   logic [7:0] m_act  [NCH];
   logic [2:0] m_out;

   always #10 clk = ~clk;

   pwm3_fast dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .ch_enable(ch_enable), .pwm_out(pwm_out)
   );

   function automatic int high_ticks(input logic [7:0] v);
      return int'(v) + 1;
   endfunction

   task automatic check(input string req, input int act_v, input int exp_v, input string what);
      n_cmp++;
      if (act_v != exp_v) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act_v, exp_v, $time);
      end
   endtask

   task automatic model_reset();
      m_cnt = '0;
      m_out = '0;
      for (int i = 0; i < NCH; i++) begin
         m_hold[i] = '0;
         m_act[i]  = '0;
      end
   endtask

   // one clock: update the model from the applied inputs, compare at negedge
   task automatic cyc();
      logic       wrap;
      logic [7:0] cnt_n;
      logic [7:0] act_n;
      logic       hit;
      @(posedge clk);
      wrap  = tick_en && (m_cnt == 8'hFF);
      cnt_n = tick_en ? m_cnt + 8'd1 : m_cnt;
      for (int i = 0; i < NCH; i++) begin
         hit   = wr_en && (int'(wr_sel) == i);
         act_n = wrap ? (hit ? wr_data : m_hold[i]) : m_act[i];
         if (hit) m_hold[i] = wr_data;
         m_act[i] = act_n;
         m_out[i] = ch_enable[i] && (cnt_n <= act_n);
      end
      m_cnt = cnt_n;
      @(negedge clk);
      if ($isunknown(pwm_out)) check("R11", 1, 0, "unknown output");
      else check(cur_req, int'(pwm_out), int'(m_out), "outputs");
   endtask

   task automatic write(input int sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = 2'(sel); wr_data = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic run(input int n);
      for (int k = 0; k < n; k++) cyc();
   endtask

   // counts high ticks of one channel over one full period starting at count 0
   task automatic measure(input int ch, input int exp_v, input string req);
      int hi = 0;
      tick_en = 1'b1;
      while (m_cnt != 8'h00) cyc();
      for (int k = 0; k < 256; k++) begin
         if (pwm_out[ch]) hi++;
         cyc();
      end
      check(req, hi, exp_v, "high ticks per period");
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(negedge clk);
      // R7: reset state
      check("R7", int'(pwm_out), 0, "outputs in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R7", int'(pwm_out), 0, "outputs after reset release");

      // R3: compare 0 gives a single high tick; R1 period via the tick counting
      ch_enable = 3'b111; tick_en = 1'b1;
      cur_req = "R3";
      run(300);
      measure(0, high_ticks(8'd0), "R3");
      cur_req = "R1";
      measure(2, 1, "R1");

      // R5: mid-period write is held until the wrap
      cur_req = "R5";
      while (m_cnt != 8'd50) cyc();
      write(0, 8'd100);
      check("R5", int'(pwm_out[0]), 0, "no change mid-period");
      run(300);
      measure(0, high_ticks(8'd100), "R2");

      // R4: TOP keeps the output high
      cur_req = "R4";
      write(0, 8'hFF); write(1, 8'hFF); write(2, 8'hFF);
      run(600);
      measure(1, 256, "R4");

      // R8: write in the wrap cycle governs the new period
      cur_req = "R8";
      while (m_cnt != 8'hFF) cyc();
      write(1, 8'd10);
      check("R8", int'(pwm_out[1]), 1, "new period starts high");
      run(12);
      check("R8", int'(pwm_out[1]), 0, "new value already in force");
      measure(1, high_ticks(8'd10), "R8");

      // R9: out-of-range select changes nothing
      cur_req = "R9";
      write(3, 8'd7);
      run(300);
      measure(2, 256, "R9");
      measure(1, high_ticks(8'd10), "R9");

      // R6: disabled channel reads low
      cur_req = "R6";
      ch_enable = 3'b011;
      run(300);
      measure(2, 0, "R6");
      ch_enable = 3'b111;

      // R10: gaps in tick_en freeze the block
      cur_req = "R10";
      for (int k = 0; k < 400; k++) begin
         tick_en = ($urandom % 2) == 0;
         cyc();
      end

      // R2: random mix of writes, enables and ticks
      cur_req = "R2";
      for (int k = 0; k < 6000; k++) begin
         tick_en   = ($urandom % 4) != 0;
         ch_enable = ($urandom % 16 == 0) ? 3'($urandom) : ch_enable;
         wr_en     = ($urandom % 40) == 0;
         wr_sel    = 2'($urandom);
         wr_data   = ($urandom % 4 == 0) ? (($urandom % 2) ? 8'hFF : 8'h00) : 8'($urandom);
         cyc();
      end
      wr_en = 1'b0;

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule